// File: doc/BRIEF.md
# Shared-Buffer Multicast Frame Switch

This block is a small store-and-forward switch with `NPORT` byte-wide receive streams and `NPORT` byte-wide transmit streams. One input at a time is granted for a whole frame. The frame is written once into a pool of shared frame buffers. When its final byte arrives, a fixed routing table is consulted, and the buffer's handle is appended to the handle queue of every destination port. A frame sent to several ports is therefore held in one copy only.

The low four bits of the first byte of a frame carry a link identifier. That identifier indexes the routing table, which is supplied as a static input. The table is never learned from traffic. Each output port sends its queued frames in arrival order. A buffer carries a count of the destinations that still owe a transmission. The buffer returns to the free pool once the last of those destinations has finished sending the frame.

Top module: `sw_mcast_switch`

## Requirements
- R1: After reset, every `out_valid` bit is 0, `drop_count` is 0, all buffers are free and all handle queues are empty.
- R2: At most one `in_ready` bit is high at a time. When idle, the switch grants the first input with `in_valid` high, searching upward (wrapping) from the port after the previously granted one; the first search after reset starts at port 0. The grant stays on that port, with `in_ready` high, up to and including the beat with `in_last`.
- R3: Store-and-forward: a frame's first byte appears on an output no earlier than the cycle after its last input byte was accepted.
- R4: Bits [3:0] of a frame's first byte select entry `route_map[id]`. Bit p of that entry sends the frame to output p, and several bits set give multicast from one stored copy.
- R5: A frame whose routing entry is all zero is accepted and produces no output. Its buffer is freed at once.
- R6: Each output sends its frames in the order they were queued to it; `out_valid[p]` is high exactly while that queue is non-empty.
- R7: Output p presents the frame's bytes in order on `out_data[p]`, with `out_last[p]` on the final byte. A byte is held stable while `out_valid[p]` is high and `out_ready[p]` is low.
- R8: A buffer is returned to the free pool in the cycle after the last of its destinations sends the final byte. Frames arriving later can then reuse it.
- R9: If no buffer is free when the first byte of a frame is accepted, the whole frame is still consumed but discarded, and `drop_count` increases by exactly one.
- R10: At commit time, a destination whose handle queue already holds `QDEPTH` entries is skipped. Other destinations still receive the frame, and the skipped one does not hold the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NPORT | Per-input byte valid |
| in_data | input | NPORT x 8 | Per-input byte |
| in_last | input | NPORT | Per-input final byte marker |
| in_ready | output | NPORT | Per-input byte accept |
| out_valid | output | NPORT | Per-output byte valid |
| out_data | output | NPORT x 8 | Per-output byte |
| out_last | output | NPORT | Per-output final byte marker |
| out_ready | input | NPORT | Per-output byte accept |
| route_map | input | NVL x NPORT | Static destination mask per link identifier |
| drop_count | output | DROPW | Frames discarded for lack of a free buffer |

## Verification
The assertions assume that each source does not change its data while its valid is high and ready is low. They also assume that no frame is longer than `BUF_BYTES` and that the routing table stays fixed while traffic flows. The bench sends frames through a driver that raises `in_valid` and keeps its byte steady until the grant accepts it. Frame lengths are drawn from 1 to `BUF_BYTES`, and `route_map` is set once before reset is released. Output back-pressure is either constant or random per cycle; neither breaks these assumptions.

// File: rtl/sw_pkg.sv
package sw_pkg;
    typedef enum logic [1:0] {
        ING_IDLE  = 2'd0,
        ING_STORE = 2'd1,
        ING_SKIP  = 2'd2
    } ing_state_e;
endpackage

// File: rtl/sw_bufpool.sv
module sw_bufpool #(
    parameter int NPORT     = 3,
    parameter int NBUF      = 4,
    parameter int BUF_BYTES = 16,
    localparam int BW = $clog2(NBUF),
    localparam int IW = $clog2(BUF_BYTES),
    localparam int LW = $clog2(BUF_BYTES + 1),
    localparam int CW = $clog2(NPORT + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc_i,
    input  logic                      wr_en_i,
    input  logic [BW-1:0]             wr_buf_i,
    input  logic [IW-1:0]             wr_idx_i,
    input  logic [7:0]                wr_data_i,
    input  logic                      commit_i,
    input  logic [BW-1:0]             commit_buf_i,
    input  logic [CW-1:0]             commit_cnt_i,
    input  logic [LW-1:0]             commit_len_i,
    input  logic [NPORT-1:0]          rel_i,
    input  logic [NPORT-1:0][BW-1:0]  rel_buf_i,
    input  logic [NPORT-1:0][BW-1:0]  rd_buf_i,
    input  logic [NPORT-1:0][IW-1:0]  rd_idx_i,
    output logic [NPORT-1:0][7:0]     rd_data_o,
    output logic [NPORT-1:0][LW-1:0]  rd_len_o,
    output logic                      free_ok_o,
    output logic [BW-1:0]             free_idx_o
);
    typedef struct packed {
        logic [NBUF-1:0][BUF_BYTES-1:0][7:0] mem;
        logic [NBUF-1:0][LW-1:0]             len;
        logic [NBUF-1:0][CW-1:0]             cnt;
        logic [NBUF-1:0]                     free;
    } pool_t;

    pool_t s_q, s_d;

    // lowest-numbered free buffer
    always_comb begin
        free_idx_o = '0;
        for (int b = NBUF - 1; b >= 0; b--) begin
            if (s_q.free[b]) free_idx_o = BW'(b);
        end
        free_ok_o = |s_q.free;
    end

    always_comb begin
        logic [CW-1:0] dec;
        s_d = s_q;
        if (wr_en_i) s_d.mem[wr_buf_i][wr_idx_i] = wr_data_i;
        if (alloc_i) s_d.free[free_idx_o] = 1'b0;
        if (commit_i) begin
            s_d.len[commit_buf_i] = commit_len_i;
            s_d.cnt[commit_buf_i] = commit_cnt_i;
            if (commit_cnt_i == '0) s_d.free[commit_buf_i] = 1'b1;
        end
        for (int b = 0; b < NBUF; b++) begin
            dec = '0;
            for (int p = 0; p < NPORT; p++) begin
                if (rel_i[p] && rel_buf_i[p] == BW'(b)) dec = dec + CW'(1);
            end
            if (dec != '0) begin
                s_d.cnt[b] = s_q.cnt[b] - dec;
                if (s_q.cnt[b] == dec) s_d.free[b] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.free <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        assign rd_data_o[p] = s_q.mem[rd_buf_i[p]][rd_idx_i[p]];
        assign rd_len_o[p]  = s_q.len[rd_buf_i[p]];
    end
endmodule

// File: rtl/sw_outq.sv
module sw_outq #(
    parameter int NBUF      = 4,
    parameter int BUF_BYTES = 16,
    parameter int QDEPTH    = 2,
    localparam int BW  = $clog2(NBUF),
    localparam int IW  = $clog2(BUF_BYTES),
    localparam int LW  = $clog2(BUF_BYTES + 1),
    localparam int QW  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
    localparam int QCW = $clog2(QDEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [BW-1:0] push_buf_i,
    output logic          full_o,
    output logic [BW-1:0] rd_buf_o,
    output logic [IW-1:0] rd_idx_o,
    input  logic [LW-1:0] rd_len_i,
    input  logic [7:0]    rd_data_i,
    input  logic          ready_i,
    output logic          valid_o,
    output logic [7:0]    data_o,
    output logic          last_o,
    output logic          rel_o,
    output logic [BW-1:0] rel_buf_o
);
    typedef struct packed {
        logic [QDEPTH-1:0][BW-1:0] slot;
        logic [QW-1:0]             head;
        logic [QW-1:0]             tail;
        logic [QCW-1:0]            count;
        logic [IW-1:0]             idx;
    } q_t;

    q_t s_q, s_d;

    always_comb begin
        logic fire;
        logic done;
        s_d       = s_q;
        valid_o   = (s_q.count != '0);
        rd_buf_o  = s_q.slot[s_q.head];
        rd_idx_o  = s_q.idx;
        data_o    = rd_data_i;
        last_o    = valid_o && ((LW'(s_q.idx) + LW'(1)) == rd_len_i);
        full_o    = (s_q.count == QCW'(QDEPTH));
        fire      = valid_o && ready_i;
        done      = fire && last_o;
        rel_o     = done;
        rel_buf_o = s_q.slot[s_q.head];
        if (fire) begin
            if (last_o) begin
                s_d.idx  = '0;
                s_d.head = (s_q.head == QW'(QDEPTH - 1)) ? '0 : s_q.head + QW'(1);
            end else begin
                s_d.idx = s_q.idx + IW'(1);
            end
        end
        if (push_i) begin
            s_d.slot[s_q.tail] = push_buf_i;
            s_d.tail = (s_q.tail == QW'(QDEPTH - 1)) ? '0 : s_q.tail + QW'(1);
        end
        s_d.count = s_q.count + QCW'(push_i) - QCW'(done);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sw_ingress.sv
module sw_ingress
    import sw_pkg::*;
#(
    parameter int NPORT     = 3,
    parameter int NBUF      = 4,
    parameter int BUF_BYTES = 16,
    parameter int NVL       = 16,
    parameter int DROPW     = 16,
    localparam int BW = $clog2(NBUF),
    localparam int IW = $clog2(BUF_BYTES),
    localparam int LW = $clog2(BUF_BYTES + 1),
    localparam int CW = $clog2(NPORT + 1),
    localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int VW = $clog2(NVL)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NPORT-1:0]           in_valid_i,
    input  logic [NPORT-1:0][7:0]      in_data_i,
    input  logic [NPORT-1:0]           in_last_i,
    output logic [NPORT-1:0]           in_ready_o,
    input  logic [NVL-1:0][NPORT-1:0]  route_i,
    input  logic                       free_ok_i,
    input  logic [BW-1:0]              free_idx_i,
    input  logic [NPORT-1:0]           q_full_i,
    output logic                       alloc_o,
    output logic                       wr_en_o,
    output logic [BW-1:0]              wr_buf_o,
    output logic [IW-1:0]              wr_idx_o,
    output logic [7:0]                 wr_data_o,
    output logic                       commit_o,
    output logic [BW-1:0]              commit_buf_o,
    output logic [CW-1:0]              commit_cnt_o,
    output logic [LW-1:0]              commit_len_o,
    output logic [NPORT-1:0]           push_o,
    output logic [DROPW-1:0]           drops_o
);
    typedef struct packed {
        ing_state_e     st;
        logic [PW-1:0]  owner;
        logic [PW-1:0]  rr;
        logic [BW-1:0]  bufh;
        logic [LW-1:0]  idx;
        logic [VW-1:0]  vl;
        logic [DROPW-1:0] drops;
    } ing_t;

    ing_t s_q, s_d;

    always_comb begin
        int            c;
        logic          take;
        logic [PW-1:0] sel;
        logic [VW-1:0] use_vl;
        s_d          = s_q;
        in_ready_o   = '0;
        alloc_o      = 1'b0;
        wr_en_o      = 1'b0;
        wr_buf_o     = s_q.bufh;
        wr_idx_o     = IW'(s_q.idx);
        wr_data_o    = in_data_i[s_q.owner];
        commit_o     = 1'b0;
        commit_buf_o = s_q.bufh;
        commit_len_o = (s_q.idx < LW'(BUF_BYTES)) ? s_q.idx + LW'(1) : s_q.idx;
        use_vl       = s_q.vl;
        take         = 1'b0;
        sel          = s_q.owner;
        case (s_q.st)
            ING_IDLE: begin
                for (int k = NPORT - 1; k >= 0; k--) begin
                    c = (int'(s_q.rr) + k) % NPORT;
                    if (in_valid_i[PW'(c)]) begin
                        sel  = PW'(c);
                        take = 1'b1;
                    end
                end
                if (take) begin
                    in_ready_o[sel] = 1'b1;
                    s_d.owner = sel;
                    s_d.rr    = PW'((int'(sel) + 1) % NPORT);
                    if (free_ok_i) begin
                        alloc_o      = 1'b1;
                        wr_en_o      = 1'b1;
                        wr_buf_o     = free_idx_i;
                        wr_idx_o     = '0;
                        wr_data_o    = in_data_i[sel];
                        use_vl       = in_data_i[sel][VW-1:0];
                        s_d.bufh     = free_idx_i;
                        s_d.idx      = LW'(1);
                        s_d.vl       = use_vl;
                        commit_buf_o = free_idx_i;
                        commit_len_o = LW'(1);
                        if (in_last_i[sel]) commit_o = 1'b1;
                        else                s_d.st   = ING_STORE;
                    end else begin
                        s_d.drops = s_q.drops + DROPW'(1);
                        if (!in_last_i[sel]) s_d.st = ING_SKIP;
                    end
                end
            end
            ING_STORE: begin
                in_ready_o[s_q.owner] = 1'b1;
                if (in_valid_i[s_q.owner]) begin
                    wr_en_o = (s_q.idx < LW'(BUF_BYTES));
                    if (s_q.idx < LW'(BUF_BYTES)) s_d.idx = s_q.idx + LW'(1);
                    if (in_last_i[s_q.owner]) begin
                        commit_o = 1'b1;
                        s_d.st   = ING_IDLE;
                    end
                end
            end
            default: begin
                in_ready_o[s_q.owner] = 1'b1;
                if (in_valid_i[s_q.owner] && in_last_i[s_q.owner]) s_d.st = ING_IDLE;
            end
        endcase
        push_o       = commit_o ? (route_i[use_vl] & ~q_full_i) : '0;
        commit_cnt_o = CW'($countones(push_o));
        drops_o      = s_q.drops;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sw_mcast_switch.sv
module sw_mcast_switch #(
    parameter int NPORT     = 3,
    parameter int NBUF      = 4,
    parameter int BUF_BYTES = 16,
    parameter int QDEPTH    = 2,
    parameter int NVL       = 16,
    parameter int DROPW     = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NPORT-1:0]          in_valid,
    input  logic [NPORT-1:0][7:0]     in_data,
    input  logic [NPORT-1:0]          in_last,
    output logic [NPORT-1:0]          in_ready,
    output logic [NPORT-1:0]          out_valid,
    output logic [NPORT-1:0][7:0]     out_data,
    output logic [NPORT-1:0]          out_last,
    input  logic [NPORT-1:0]          out_ready,
    input  logic [NVL-1:0][NPORT-1:0] route_map,
    output logic [DROPW-1:0]          drop_count
);
    localparam int BW = $clog2(NBUF);
    localparam int IW = $clog2(BUF_BYTES);
    localparam int LW = $clog2(BUF_BYTES + 1);
    localparam int CW = $clog2(NPORT + 1);

    logic                     alloc, wr_en, commit, free_ok;
    logic [BW-1:0]            wr_buf, commit_buf, free_idx;
    logic [IW-1:0]            wr_idx;
    logic [7:0]               wr_data;
    logic [CW-1:0]            commit_cnt;
    logic [LW-1:0]            commit_len;
    logic [NPORT-1:0]         push, q_full, rel;
    logic [NPORT-1:0][BW-1:0] rel_buf, rd_buf;
    logic [NPORT-1:0][IW-1:0] rd_idx;
    logic [NPORT-1:0][7:0]    rd_data;
    logic [NPORT-1:0][LW-1:0] rd_len;

    sw_ingress #(
        .NPORT(NPORT), .NBUF(NBUF), .BUF_BYTES(BUF_BYTES), .NVL(NVL), .DROPW(DROPW)
    ) u_ing (
        .clk(clk), .rst_n(rst_n),
        .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last), .in_ready_o(in_ready),
        .route_i(route_map), .free_ok_i(free_ok), .free_idx_i(free_idx), .q_full_i(q_full),
        .alloc_o(alloc), .wr_en_o(wr_en), .wr_buf_o(wr_buf), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
        .commit_o(commit), .commit_buf_o(commit_buf), .commit_cnt_o(commit_cnt),
        .commit_len_o(commit_len), .push_o(push), .drops_o(drop_count)
    );

    sw_bufpool #(
        .NPORT(NPORT), .NBUF(NBUF), .BUF_BYTES(BUF_BYTES)
    ) u_pool (
        .clk(clk), .rst_n(rst_n), .alloc_i(alloc),
        .wr_en_i(wr_en), .wr_buf_i(wr_buf), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
        .commit_i(commit), .commit_buf_i(commit_buf), .commit_cnt_i(commit_cnt),
        .commit_len_i(commit_len), .rel_i(rel), .rel_buf_i(rel_buf),
        .rd_buf_i(rd_buf), .rd_idx_i(rd_idx), .rd_data_o(rd_data), .rd_len_o(rd_len),
        .free_ok_o(free_ok), .free_idx_o(free_idx)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_out
        sw_outq #(
            .NBUF(NBUF), .BUF_BYTES(BUF_BYTES), .QDEPTH(QDEPTH)
        ) u_q (
            .clk(clk), .rst_n(rst_n),
            .push_i(push[p]), .push_buf_i(commit_buf), .full_o(q_full[p]),
            .rd_buf_o(rd_buf[p]), .rd_idx_o(rd_idx[p]), .rd_len_i(rd_len[p]), .rd_data_i(rd_data[p]),
            .ready_i(out_ready[p]), .valid_o(out_valid[p]), .data_o(out_data[p]), .last_o(out_last[p]),
            .rel_o(rel[p]), .rel_buf_o(rel_buf[p])
        );
    end
endmodule

// File: rtl/sw_mcast_switch_chk.sv
module sw_mcast_switch_chk #(
    parameter int NPORT = 3,
    parameter int DROPW = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NPORT-1:0]      in_valid,
    input logic [NPORT-1:0]      in_last,
    input logic [NPORT-1:0]      in_ready,
    input logic [NPORT-1:0]      out_valid,
    input logic [NPORT-1:0][7:0] out_data,
    input logic [NPORT-1:0]      out_last,
    input logic [NPORT-1:0]      out_ready,
    input logic [DROPW-1:0]      drop_count
);
    a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ready));

    a_r9_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
        drop_count != $past(drop_count) |-> drop_count == $past(drop_count) + DROPW'(1));

    a_r9_drop_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        drop_count != $past(drop_count) |-> $past(|(in_valid & in_ready)));

    for (genvar p = 0; p < NPORT; p++) begin : g_p
        a_r2_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid[p] && in_ready[p] && !in_last[p] |=> in_ready[p]);

        a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[p] && !out_ready[p] |=>
                out_valid[p] && $stable(out_data[p]) && $stable(out_last[p]));
    end
endmodule

bind sw_mcast_switch sw_mcast_switch_chk #(.NPORT(NPORT), .DROPW(DROPW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
    .drop_count(drop_count)
);

// File: tb/sw_mcast_switch_test.sv
module sw_mcast_switch_test;
    localparam int N = 3, NB = 4, BB = 16, QD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]       in_valid = '0, in_last = '0, out_ready = '0;
    logic [N-1:0][7:0]  in_data = '0;
    logic [N-1:0]       in_ready, out_valid, out_last;
    logic [N-1:0][7:0]  out_data;
    logic [15:0][N-1:0] route;
    logic [15:0]        drop_count;

    always #10 clk = ~clk;

    sw_mcast_switch #(.NPORT(N), .NBUF(NB), .BUF_BYTES(BB), .QDEPTH(QD)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready), .route_map(route), .drop_count(drop_count)
    );

    int vectors = 0, fails = 0, cyc = 0;
    int seen[N];
    bit rmode = 0;
    logic [N-1:0] rfixed = '0;

    // behavioural reference state
    int m_st = 0, m_owner = 0, m_rr = 0, m_buf = 0, m_idx = 0, m_vl = 0, m_drops = 0;
    bit m_free[NB];
    int m_ref[NB], m_len[NB];
    int m_mem[NB][BB];
    int m_q[N][$];
    int m_rd[N];

    task automatic chk(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    task automatic model_step();
        int sel, lowfree, h;
        int qsz[N];
        sel = -1;
        if (m_st == 0) begin
            for (int k = 0; k < N; k++) begin
                int c = (m_rr + k) % N;
                if (sel < 0 && in_valid[c]) sel = c;
            end
        end else sel = m_owner;
        for (int p = 0; p < N; p++) chk("R2", "in_ready", int'(in_ready[p]), int'(sel == p));
        for (int p = 0; p < N; p++) begin
            bit ev = m_q[p].size() > 0;
            chk("R6", "out_valid", int'(out_valid[p]), int'(ev));
            if (ev) begin
                h = m_q[p][0];
                chk("R7", "out_data", int'(out_data[p]), m_mem[h][m_rd[p]]);
                chk("R7", "out_last", int'(out_last[p]), int'(m_rd[p] == m_len[h] - 1));
            end
        end
        chk("R9", "drop_count", int'(drop_count), m_drops);
        for (int p = 0; p < N; p++) qsz[p] = m_q[p].size();
        lowfree = -1;
        for (int b = NB - 1; b >= 0; b--) if (m_free[b]) lowfree = b;
        // outputs
        for (int p = 0; p < N; p++) begin
            if (qsz[p] > 0 && out_ready[p]) begin
                h = m_q[p][0];
                if (m_rd[p] == m_len[h] - 1) begin
                    void'(m_q[p].pop_front());
                    m_rd[p] = 0;
                    seen[p]++;
                    m_ref[h]--;
                    if (m_ref[h] == 0) m_free[h] = 1;   // R8
                end else m_rd[p]++;
            end
        end
        // ingress
        if (sel >= 0 && in_valid[sel]) begin
            int d = int'(in_data[sel]);
            bit l = in_last[sel];
            bit do_commit = 0;
            if (m_st == 0) begin
                m_rr = (sel + 1) % N;
                m_owner = sel;
                if (lowfree >= 0) begin
                    m_free[lowfree] = 0;
                    m_buf = lowfree;
                    m_mem[lowfree][0] = d;
                    m_idx = 1;
                    m_vl = d % 16;
                    if (l) do_commit = 1; else m_st = 1;
                end else begin
                    m_drops++;
                    if (!l) m_st = 2;
                end
            end else if (m_st == 1) begin
                m_mem[m_buf][m_idx] = d;
                m_idx++;
                if (l) begin do_commit = 1; m_st = 0; end
            end else if (l) m_st = 0;
            if (do_commit) begin
                int cnt = 0;
                for (int p = 0; p < N; p++) begin
                    if (route[m_vl][p] && qsz[p] < QD) begin   // R10
                        m_q[p].push_back(m_buf);
                        cnt++;
                    end
                end
                m_ref[m_buf] = cnt;
                m_len[m_buf] = m_idx;
                if (cnt == 0) m_free[m_buf] = 1;               // R5
            end
        end
    endtask

    // per-cycle comparison and watchdog
    initial begin
        for (int b = 0; b < NB; b++) m_free[b] = 1;
        forever begin
            @(negedge clk);
            #5;
            if (rst_n) model_step();
            cyc++;
            if (cyc > 150000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
                summary();
                $finish;
            end
        end
    end

    always @(negedge clk) out_ready <= rmode ? N'($urandom) : rfixed;

    task automatic send(int p, int vl, int len, bit sf);
        int i = 0;
        while (i < len) begin
            @(negedge clk);
            in_valid[p] = 1'b1;
            in_data[p]  = (i == 0) ? {4'($urandom), 4'(vl)} : 8'($urandom);
            in_last[p]  = (i == len - 1);
            #5;
            if (in_ready[p]) begin
                if (sf && i < len - 1)   // R3: nothing leaves before the last byte
                    chk("R3", "out_valid while receiving", int'(|out_valid), 0);
                i++;
            end
        end
        @(negedge clk);
        in_valid[p] = 1'b0;
        in_last[p]  = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int base[N];
        for (int v = 0; v < 16; v++) route[v] = N'(v % 8);
        idle(4);
        #5;
        chk("R1", "out_valid in reset", int'(out_valid), 0);
        chk("R1", "drop_count in reset", int'(drop_count), 0);
        @(negedge clk);
        rst_n = 1'b1;
        rfixed = '1;
        #5;
        chk("R1", "out_valid after reset", int'(out_valid), 0);
        chk("R1", "in_ready after reset", int'(in_ready), 0);

        // single frames through each routing pattern, including empty mask
        foreach (base[p]) base[p] = seen[p];
        send(0, 1, 4, 1);  idle(20);
        send(1, 2, 5, 1);  idle(20);
        send(2, 3, 6, 1);  idle(20);
        send(0, 4, 7, 1);  idle(20);
        send(1, 7, 10, 1); idle(20);
        send(2, 0, 3, 1);  idle(20);
        send(0, 5, 8, 1);  idle(20);
        send(1, 6, 9, 1);  idle(20);
        send(2, 7, 1, 0);  idle(20);
        for (int p = 0; p < N; p++) chk("R4", "frames per output", seen[p] - base[p], 5);
        chk("R5", "zero-mask frame is no drop", int'(drop_count), 0);

        // contention among inputs
        repeat (2) begin
            fork
                send(0, 7, 5, 0);
                send(1, 3, 12, 0);
                send(2, 6, 16, 0);
            join
        end
        idle(80);

        // full queues and pool exhaustion
        foreach (base[p]) base[p] = seen[p];
        rfixed = '0;
        idle(2);
        send(0, 1, 4, 0);
        send(1, 1, 3, 0);
        send(2, 7, 5, 0);
        send(0, 2, 2, 0);
        send(1, 4, 6, 0);
        chk("R9", "drop after pool exhausted", int'(drop_count), 1);
        rfixed = '1;
        idle(60);
        chk("R10", "port0 skipped when full", seen[0] - base[0], 2);
        chk("R10", "port1 frames", seen[1] - base[1], 2);
        chk("R10", "port2 frames", seen[2] - base[2], 1);
        foreach (base[p]) base[p] = seen[p];
        send(2, 7, 8, 0);
        idle(30);
        for (int p = 0; p < N; p++) chk("R8", "buffer reused after release", seen[p] - base[p], 1);
        chk("R8", "no drop after release", int'(drop_count), 1);

        // random traffic with random back-pressure
        rmode = 1;
        for (int it = 0; it < 60; it++) begin
            fork
                send(0, int'($urandom % 16), 1 + int'($urandom % BB), 0);
                send(1, int'($urandom % 16), 1 + int'($urandom % BB), 0);
                send(2, int'($urandom % 16), 1 + int'($urandom % BB), 0);
            join
        end
        rmode = 0;
        rfixed = '1;
        idle(200);
        chk("R6", "all queues drained", int'(out_valid), 0);
        summary();
        $finish;
    end
endmodule